// File: doc/BRIEF.md
# Compare-Channel Timer with Watchdog Reset

This block is a free-running up-counter that advances on each cycle where a tick-enable input is high, plus a set of compare channels. Each channel holds a compare value; when the counter equals that value on a tick, the channel's sticky status bit sets. Each channel's interrupt line is its status bit masked by a per-channel enable. Software reads the counter either directly or through a snapshot register, which freezes a copy of the count on request. The counter can then be read once, consistently, while it keeps running.

The highest-numbered channel doubles as a system watchdog. There is no kick register. Software services the watchdog by taking a snapshot, adding the timeout in ticks, and writing the sum as that channel's new compare value, so the compare point always stays ahead of the counter. If the counter reaches it while the watchdog is armed and that channel's interrupt enable is set, a one-cycle reset pulse is issued. Time remaining is the compare value minus the counter, modulo the counter width.

A single-cycle register bus gives access to all of this. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `match_timer_wdt`

## Requirements
- R1: After reset the counter, the snapshot, the status bits, the interrupt enables and the watchdog arm bit are all zero, every compare register reads all-ones in the counter width, and irq_o and wdt_rst_o are low.
- R2: The counter (offset 0x00, read-only) increments by one, modulo 2^CNT_W, at every clock edge where tick_i is high, and holds otherwise. Writes to offset 0x00 have no effect.
- R3: A write with bit 0 set to offset 0x30 copies the counter value present at that edge, before any increment in the same cycle, into the snapshot at offset 0x34. The snapshot holds until the next such write, and a write with bit 0 clear captures nothing.
- R4: Compare channel n is read/write at offset 0x08 + 4n. At a tick edge where the counter equals channel n's compare value, status bit n sets. The comparison is modulo 2^CNT_W, so a compare value that has wrapped past zero still fires.
- R5: The status register at offset 0x20 holds channel n in bit n. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R6: If a channel's compare hit and a write-1-clear of its status bit fall in the same cycle, the bit ends up set.
- R7: The interrupt-enable register at offset 0x24 (bit n = channel n) is read/write, and irq_o[n] is status bit n AND enable bit n. Clearing an enable drops the line but keeps the status bit.
- R8: Writing bit 0 = 1 to offset 0x28 arms the watchdog, and writing bit 0 = 0 disarms it. The arm bit reads back in bit 0.
- R9: wdt_rst_o is high for exactly the one cycle that follows the tick edge where the last channel hits, and only when, at that edge, the watchdog is armed and that channel's enable bit is set.
- R10: Compare value minus counter, both read back over the bus, gives the remaining ticks modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable strobe at the tick rate |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | N_CH | Per-channel interrupt, status AND enable |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
Two pairs of events can land on the same edge: a compare hit with a write-1-clear of the same status bit, and a snapshot request with a counter increment. The bench provokes each by raising tick_i in the same cycle as the bus write. A compare value equal to the current count makes the hit coincide with the clear, and the result is judged correct when the status bit reads set. For the snapshot, the captured value must be the count before that cycle's increment, while the live counter has already moved one step on. A reduced 8-bit counter lets a sweep over every channel use compare distances that wrap past zero.

// File: rtl/mtw_pkg.sv
package mtw_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_CNT    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CMP0   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_IE     = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_ARM    = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_SNAP   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_SNAPRD = 8'h34;
endpackage

// File: rtl/mtw_counter.sv
module mtw_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] snap_o
);
  logic [CNT_W-1:0] cnt_q, snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (snap_i) snap_q <= cnt_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign snap_o = snap_q;

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
  a_r3_snap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> snap_o == $past(cnt_o));
  a_r3_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_o));
endmodule

// File: rtl/mtw_cmp_bank.sv
module mtw_cmp_bank #(
  parameter int unsigned N_CH  = 6,
  parameter int unsigned CNT_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [N_CH-1:0]            wr_sel_i,
  input  logic [CNT_W-1:0]           wr_val_i,
  input  logic [N_CH-1:0]            clr_i,
  output logic [N_CH-1:0][CNT_W-1:0] cmp_o,
  output logic [N_CH-1:0]            hit_o,
  output logic [N_CH-1:0]            stat_o
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] cmp_q;
    logic             stat_q;
    logic             hit;

    assign hit = tick_i && (cnt_i == cmp_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_q  <= '1;
        stat_q <= 1'b0;
      end else begin
        if (wr_sel_i[ch]) cmp_q <= wr_val_i;
        // a hit in the clearing cycle must not be lost
        if (hit)             stat_q <= 1'b1;
        else if (clr_i[ch])  stat_q <= 1'b0;
      end
    end

    assign cmp_o[ch]  = cmp_q;
    assign hit_o[ch]  = hit;
    assign stat_o[ch] = stat_q;

    a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o[ch] |=> stat_o[ch]);
    a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[ch] && !hit_o[ch] |=> !stat_o[ch]);
    a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_o[ch] && !clr_i[ch] |=> stat_o[ch]);
  end
endmodule

// File: rtl/mtw_wdt.sv
module mtw_wdt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_wr_i,
  input  logic arm_val_i,
  input  logic hit_i,
  input  logic ie_i,
  output logic armed_o,
  output logic rst_pulse_o
);
  logic armed_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (arm_wr_i) armed_q <= arm_val_i;
      pulse_q <= hit_i && armed_q && ie_i;
    end
  end

  assign armed_o     = armed_q;
  assign rst_pulse_o = pulse_q;

  a_r9_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |=> !rst_pulse_o);
  a_r9_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |-> $past(armed_o && ie_i && hit_i));
  a_r8_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_wr_i && !arm_val_i |=> !armed_o);
  a_r8_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_wr_i && arm_val_i |=> armed_o);
endmodule

// File: rtl/match_timer_wdt.sv
module match_timer_wdt
  import mtw_pkg::*;
#(
  parameter int unsigned N_CH  = 6,
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [N_CH-1:0]   irq_o,
  output logic              wdt_rst_o
);
  localparam int unsigned WD_CH = N_CH - 1;

  logic [CNT_W-1:0]           cnt, snap;
  logic [N_CH-1:0][CNT_W-1:0] cmp;
  logic [N_CH-1:0]            hit, stat, ie_q, wr_sel, clr;
  logic                       snap_req, arm_wr, armed;

  always_comb begin
    for (int n = 0; n < N_CH; n++)
      wr_sel[n] = wr_en_i && (addr_i == ADDR_W'(OFS_CMP0 + 4 * n));
  end

  assign clr      = (wr_en_i && addr_i == OFS_STAT) ? wr_data_i[N_CH-1:0] : '0;
  assign snap_req = wr_en_i && addr_i == OFS_SNAP && wr_data_i[0];
  assign arm_wr   = wr_en_i && addr_i == OFS_ARM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ie_q <= '0;
    else if (wr_en_i && addr_i == OFS_IE) ie_q <= wr_data_i[N_CH-1:0];
  end

  mtw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .snap_i (snap_req),
    .cnt_o  (cnt),
    .snap_o (snap)
  );

  mtw_cmp_bank #(.N_CH(N_CH), .CNT_W(CNT_W)) u_bank (
    .clk_i, .rst_ni, .tick_i,
    .cnt_i    (cnt),
    .wr_sel_i (wr_sel),
    .wr_val_i (wr_data_i[CNT_W-1:0]),
    .clr_i    (clr),
    .cmp_o    (cmp),
    .hit_o    (hit),
    .stat_o   (stat)
  );

  mtw_wdt u_wdt (
    .clk_i, .rst_ni,
    .arm_wr_i    (arm_wr),
    .arm_val_i   (wr_data_i[0]),
    .hit_i       (hit[WD_CH]),
    .ie_i        (ie_q[WD_CH]),
    .armed_o     (armed),
    .rst_pulse_o (wdt_rst_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      OFS_CNT:    rd_data_o = DATA_W'(cnt);
      OFS_STAT:   rd_data_o = DATA_W'(stat);
      OFS_IE:     rd_data_o = DATA_W'(ie_q);
      OFS_ARM:    rd_data_o = DATA_W'(armed);
      OFS_SNAPRD: rd_data_o = DATA_W'(snap);
      default:    rd_data_o = '0;
    endcase
    for (int n = 0; n < N_CH; n++)
      if (addr_i == ADDR_W'(OFS_CMP0 + 4 * n)) rd_data_o = DATA_W'(cmp[n]);
  end

  assign irq_o = stat & ie_q;

  a_r7_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == OFS_IE && wr_data_i[N_CH-1:0] == '0 |=> irq_o == '0);
  a_r9_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> stat[WD_CH]);
endmodule

// File: tb/match_timer_wdt_bench.sv
`timescale 1ns/1ps
module match_timer_wdt_bench;
  localparam int N_CH  = 6;
  localparam int CNT_W = 8;
  localparam logic [31:0] MSK = 32'hFF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N_CH-1:0] irq;
  logic        wdt_rst;

  match_timer_wdt #(.N_CH(N_CH), .CNT_W(CNT_W)) u_match_timer_wdt (
    .clk_i(clk), .rst_ni, .tick_i(tick), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq), .wdt_rst_o(wdt_rst)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_cnt = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    exp_cnt = (exp_cnt + 32'(n)) & MSK;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, m, c;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk("R1 counter", v, 0);
    rd(8'h34, v); chk("R1 snapshot", v, 0);
    rd(8'h20, v); chk("R1 status", v, 0);
    rd(8'h24, v); chk("R1 enable", v, 0);
    rd(8'h28, v); chk("R1 arm", v, 0);
    for (int ch = 0; ch < N_CH; ch++) begin
      rd(8'(8 + 4 * ch), v); chk("R1 compare", v, MSK);
    end
    chk("R1 irq", 32'(irq), 0);
    chk("R1 wdt", 32'(wdt_rst), 0);

    // R2 counting and ignored writes
    repeat (5) @(negedge clk);
    rd(8'h00, v); chk("R2 hold without tick", v, 0);
    wr(8'h00, 32'h55);
    rd(8'h00, v); chk("R2 write ignored", v, 0);
    ticks(10);
    rd(8'h00, v); chk("R2 ten ticks", v, exp_cnt);

    // R3 snapshot
    wr(8'h30, 1);
    rd(8'h34, v); chk("R3 capture", v, exp_cnt);
    c = exp_cnt;
    ticks(7);
    rd(8'h34, v); chk("R3 frozen", v, c);
    wr(8'h30, 0);
    rd(8'h34, v); chk("R3 bit0 clear no capture", v, c);
    @(negedge clk); addr = 8'h30; wdata = 1; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    c = exp_cnt; exp_cnt = (exp_cnt + 1) & MSK;
    rd(8'h34, v); chk("R3 pre-increment capture", v, c);
    rd(8'h00, v); chk("R3 counter moved", v, exp_cnt);

    // R4 R5 R7 R10 sweep over channels and distances, incl. wrap
    for (int ch = 0; ch < N_CH; ch++) begin
      for (int k = 0; k < 3; k++) begin
        int d;
        d = (k == 0) ? 1 : (k == 1) ? 5 : 250;
        wr(8'h20, 32'h3F);
        m = (exp_cnt + 32'(d)) & MSK;
        wr(8'(8 + 4 * ch), m);
        wr(8'h24, 32'(1 << ch));
        rd(8'(8 + 4 * ch), v); chk("R4 compare readback", v, m);
        rd(8'h00, c);
        chk("R10 time left", (v - c) & MSK, 32'(d));
        ticks(d);
        rd(8'h20, v); chk("R4 no early hit", (v >> ch) & 1, 0);
        ticks(1);
        rd(8'h20, v); chk("R4 hit sets status", (v >> ch) & 1, 1);
        chk("R7 irq follows", 32'(irq), 32'(1 << ch));
        wr(8'h24, 0);
        chk("R7 irq masked", 32'(irq), 0);
        rd(8'h20, v); chk("R7 status kept", (v >> ch) & 1, 1);
        wr(8'h20, ~(32'(1 << ch)) & 32'h3F);
        rd(8'h20, v); chk("R5 zero leaves bit", (v >> ch) & 1, 1);
        wr(8'h20, 32'(1 << ch));
        rd(8'h20, v); chk("R5 one clears bit", (v >> ch) & 1, 0);
      end
    end

    // R6 hit and clear in the same cycle
    for (int ch = 0; ch < N_CH; ch++) begin
      wr(8'h20, 32'h3F);
      wr(8'(8 + 4 * ch), exp_cnt);
      @(negedge clk); addr = 8'h20; wdata = 32'(1 << ch); wr_en = 1'b1; tick = 1'b1;
      @(negedge clk); wr_en = 1'b0; tick = 1'b0;
      exp_cnt = (exp_cnt + 1) & MSK;
      rd(8'h20, v); chk("R6 set wins over clear", (v >> ch) & 1, 1);
    end

    // R8 R9 watchdog enable combinations
    for (int combo = 0; combo < 4; combo++) begin
      logic en, ie5;
      en = combo[0]; ie5 = combo[1];
      wr(8'h20, 32'h3F);
      wr(8'h1C, (exp_cnt + 3) & MSK);
      wr(8'h24, ie5 ? 32'h20 : 32'h0);
      wr(8'h28, 1);
      if (!en) wr(8'h28, 0);
      rd(8'h28, v); chk("R8 arm readback", v, 32'(en));
      @(negedge clk); tick = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 no pulse before hit", 32'(wdt_rst), 0);
      @(negedge clk);
      chk("R9 pulse after hit edge", 32'(wdt_rst), 32'(en & ie5));
      @(negedge clk);
      chk("R9 pulse one cycle", 32'(wdt_rst), 0);
      tick = 1'b0;
      exp_cnt = (exp_cnt + 5) & MSK;
      rd(8'h20, v); chk("R4 last channel status", (v >> 5) & 1, 1);
      wr(8'h28, 0);
    end
    rd(8'h00, v); chk("R2 final count", v, exp_cnt);

    summary();
    $finish;
  end
endmodule